// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small shared word-addressed memory and serves several requesters through a single arbitrated port. Each requester presents an operation code, a word address and a write value. One request is accepted per clock, and the accepted requester sees a grant in that same cycle. The block reads the addressed word and, when the operation calls for it, writes the new value in that one cycle. No other requester's access can fall between the read and the write, so every read-modify-write is indivisible.

The operations are plain load and store, test-and-set on a lock word (0 free, 1 held), exchange, fetch-and-increment, and load-linked / store-conditional. A load-linked places a reservation on one address for the requester that issued it. The block keeps one such reservation per requester. A later store-conditional from that requester writes only if the reservation is still intact, and it returns 1 on success or 0 on failure. Any write to a reserved address breaks the reservation. Software can build spin locks, counters and barriers on these primitives without a cache or coherence machinery.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, no response is valid. Reset clears every reservation, so a store-conditional issued just after reset fails.
- R2: Each cycle at most one requester is granted, and only a requester whose valid is high. If any valid is high, one is granted. The search starts at the index after the last granted requester and wraps around; after reset it starts at requester 0. `req_grant` is combinational in the same cycle.
- R3: One cycle after a grant, `rsp_valid` is one-hot on the granted requester and `rsp_data` carries its result. With no grant, `rsp_valid` is all zero.
- R4: Operation code 0 (load) returns the word. Code 1 (store) writes `wdata` and returns 0. Code 7 behaves as a load.
- R5: Code 2 (test-and-set) returns the previous word and writes 1.
- R6: Code 3 (exchange) returns the previous word and writes the requester's `wdata` in the same cycle.
- R7: Code 4 (fetch-and-increment) returns the previous word and writes that value plus one, wrapping modulo 2^DW.
- R8: Code 5 (load-linked) returns the word and reserves that address for the requester. A newer load-linked from the same requester replaces its earlier reservation.
- R9: Code 6 (store-conditional) with a valid reservation on the same address writes `wdata` and returns 1.
- R10: A store-conditional with no matching reservation returns 0 and leaves memory unchanged. In both the success and the failure case, it drops that requester's reservation.
- R11: Every write (store, test-and-set, exchange, increment, successful store-conditional) clears the reservation of every requester linked to the written address, including the writer's own.
- R12: Memory words start at 0 at power-up. Reset does not alter memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 3*NREQ | Operation code per requester, 3 bits each |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write value per requester |
| req_grant | output | NREQ | One-hot accept, same cycle |
| rsp_valid | output | NREQ | One-hot response strobe, one cycle after grant |
| rsp_data | output | DW | Result of the granted operation |

## Verification
A grant is due in the same cycle as the request. The bench drives inputs at the falling edge and reads `req_grant` 1 ns later, before the rising edge that commits the operation. The response and the effect on memory are due one rising edge later. The bench therefore checks `rsp_valid` and `rsp_data` at the following falling edge, against a behavioural model that it advanced when it predicted the grant. Memory and reservation effects have no port of their own. They show up in later load, load-linked and store-conditional results, which directed sequences and a long random run on four shared addresses exercise.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int RMW_OPW = 3;

  typedef enum logic [RMW_OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } rmw_op_e;
endpackage

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int off = 1; off <= N; off++) begin
      automatic int cand = int'(last_q) + off;
      if (cand >= N) cand = cand - N;
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  assign grant = gnt_any ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/rmw_link_slot.sv
module rmw_link_slot #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic          drop_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic          armed_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      armed_q <= 1'b1;
      addr_q  <= addr_i;
    end else if (drop_i || (wr_i && addr_i == addr_q)) begin
      armed_q <= 1'b0;
    end
  end

  assign hit_o = armed_q && (addr_q == addr_i);
endmodule

// File: rtl/rmw_exec.sv
module rmw_exec
  import rmw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               en_i,
  input  logic [RMW_OPW-1:0] op_i,
  input  logic [DW-1:0]      old_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               link_ok_i,
  output logic               wr_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [DW-1:0]      rsp_o,
  output logic               link_set_o,
  output logic               link_drop_o
);
  always_comb begin
    wr_o        = 1'b0;
    wr_data_o   = wdata_i;
    rsp_o       = old_i;
    link_set_o  = 1'b0;
    link_drop_o = 1'b0;
    if (en_i) begin
      case (rmw_op_e'(op_i))
        OP_STORE: begin
          wr_o  = 1'b1;
          rsp_o = '0;
        end
        OP_TAS: begin
          wr_o      = 1'b1;
          wr_data_o = DW'(1);
        end
        OP_SWAP: wr_o = 1'b1;
        OP_FINC: begin
          wr_o      = 1'b1;
          wr_data_o = old_i + DW'(1);
        end
        OP_LL: link_set_o = 1'b1;
        OP_SC: begin
          link_drop_o = 1'b1;
          wr_o        = link_ok_i;
          rsp_o       = link_ok_i ? DW'(1) : '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import rmw_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         req_valid,
  input  logic [NREQ*RMW_OPW-1:0] req_op,
  input  logic [NREQ*AW-1:0]      req_addr,
  input  logic [NREQ*DW-1:0]      req_wdata,
  output logic [NREQ-1:0]         req_grant,
  output logic [NREQ-1:0]         rsp_valid,
  output logic [DW-1:0]           rsp_data
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IW-1:0]      gnt_idx;
  logic               gnt_any;
  logic [RMW_OPW-1:0] sel_op;
  logic [AW-1:0]      sel_addr;
  logic [DW-1:0]      sel_wdata;
  logic [DW-1:0]      old_word;
  logic [NREQ-1:0]    link_hit;
  logic               exe_wr, exe_set, exe_drop;
  logic [DW-1:0]      exe_wr_data, exe_rsp;
  logic [DW-1:0]      mem [DEPTH];

  rmw_rr_arbiter #(.N(NREQ)) u_arb (
    .clk(clk), .rst(rst),
    .req(rst ? '0 : req_valid),
    .grant(req_grant), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign sel_op    = req_op[gnt_idx*RMW_OPW +: RMW_OPW];
  assign sel_addr  = req_addr[gnt_idx*AW +: AW];
  assign sel_wdata = req_wdata[gnt_idx*DW +: DW];
  assign old_word  = mem[sel_addr];

  rmw_exec #(.DW(DW)) u_exec (
    .en_i(gnt_any), .op_i(sel_op), .old_i(old_word), .wdata_i(sel_wdata),
    .link_ok_i(link_hit[gnt_idx]),
    .wr_o(exe_wr), .wr_data_o(exe_wr_data), .rsp_o(exe_rsp),
    .link_set_o(exe_set), .link_drop_o(exe_drop)
  );

  for (genvar i = 0; i < NREQ; i++) begin : g_link
    rmw_link_slot #(.AW(AW)) u_slot (
      .clk(clk), .rst(rst),
      .set_i(exe_set && req_grant[i]),
      .drop_i(exe_drop && req_grant[i]),
      .wr_i(exe_wr),
      .addr_i(sel_addr),
      .hit_o(link_hit[i])
    );
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) mem[w] = '0;
  end

  always_ff @(posedge clk) begin
    if (exe_wr) mem[sel_addr] <= exe_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_grant;
      if (gnt_any) rsp_data <= exe_rsp;
    end
  end
endmodule

// File: rtl/rmw_unit_checker.sv
module rmw_unit_checker
  import rmw_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int DW   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [NREQ-1:0]     req_valid,
  input logic [NREQ-1:0]     req_grant,
  input logic [NREQ-1:0]     rsp_valid,
  input logic [DW-1:0]       rsp_data,
  input logic                gnt_any,
  input logic [RMW_OPW-1:0]  sel_op,
  input logic                sel_link,
  input logic                exe_wr
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> rsp_valid == '0);

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_grant));

  assert_grant_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (req_grant & ~req_valid) == '0);

  assert_grant_live_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid != '0) |-> (req_grant != '0));

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rsp_valid == $past(req_grant));

  assert_sc_result_R9: assert property (@(posedge clk) disable iff (rst)
    (gnt_any && sel_op == OP_SC) |=> rsp_data <= DW'(1));

  assert_sc_nolink_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt_any && sel_op == OP_SC && !sel_link) |-> !exe_wr);

  assert_load_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_any && (sel_op == OP_LOAD || sel_op == OP_LL)) |-> !exe_wr);
endmodule

bind atomic_rmw_unit rmw_unit_checker #(.NREQ(NREQ), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_grant(req_grant),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .gnt_any(gnt_any),
  .sel_op(sel_op), .sel_link(link_hit[gnt_idx]), .exe_wr(exe_wr)
);

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
  localparam int NREQ = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ*3-1:0]  req_op = '0;
  logic [NREQ*AW-1:0] req_addr = '0;
  logic [NREQ*DW-1:0] req_wdata = '0;
  logic [NREQ-1:0]    req_grant, rsp_valid;
  logic [DW-1:0]      rsp_data;

  atomic_rmw_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_atomic_rmw_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_mem [DEPTH];
  bit m_rv [NREQ];
  int m_ra [NREQ];
  int m_last = NREQ - 1;
  logic [NREQ-1:0] e_valid;
  int e_data;
  string e_tag;
  string tag_force = "";

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_links(int a);
    for (int r = 0; r < NREQ; r++) if (m_rv[r] && m_ra[r] == a) m_rv[r] = 0;
  endtask

  // inputs already driven at a falling edge
  task automatic run_cycle();
    int g;
    int op, a, wd, old;
    #1;
    g = -1;
    for (int off = 1; off <= NREQ; off++) begin
      int c;
      c = (m_last + off) % NREQ;
      if (g < 0 && req_valid[c]) g = c;
    end
    check("R2 grant", req_grant, (g < 0) ? 0 : (1 << g));
    e_valid = '0;
    if (g >= 0) begin
      m_last = g;
      e_valid = NREQ'(1) << g;
      op = int'(req_op[g*3 +: 3]);
      a  = int'(req_addr[g*AW +: AW]);
      wd = int'(req_wdata[g*DW +: DW]);
      old = m_mem[a];
      case (op)
        1: begin m_mem[a] = wd; clear_links(a); e_data = 0; e_tag = "R4 store"; end
        2: begin m_mem[a] = 1; clear_links(a); e_data = old; e_tag = "R5 tas"; end
        3: begin m_mem[a] = wd; clear_links(a); e_data = old; e_tag = "R6 swap"; end
        4: begin m_mem[a] = (old + 1) & 16'hFFFF; clear_links(a); e_data = old; e_tag = "R7 finc"; end
        5: begin m_rv[g] = 1; m_ra[g] = a; e_data = old; e_tag = "R8 ll"; end
        6: begin
          if (m_rv[g] && m_ra[g] == a) begin
            m_rv[g] = 0; m_mem[a] = wd; clear_links(a); e_data = 1; e_tag = "R9 sc ok";
          end else begin
            m_rv[g] = 0; e_data = 0; e_tag = "R10 sc fail";
          end
        end
        default: begin e_data = old; e_tag = "R4 load"; end
      endcase
      if (tag_force != "") e_tag = tag_force;
    end
    @(negedge clk);
    check("R3 rsp_valid", rsp_valid, e_valid);
    if (e_valid != '0) check(e_tag, rsp_data, e_data);
  endtask

  task automatic put(int r, int op, int a, int wd);
    req_valid[r] = 1'b1;
    req_op[r*3 +: 3] = 3'(op);
    req_addr[r*AW +: AW] = AW'(a);
    req_wdata[r*DW +: DW] = DW'(wd);
  endtask

  task automatic one(int r, int op, int a, int wd, string tag);
    req_valid = '0;
    put(r, op, a, wd);
    tag_force = tag;
    run_cycle();
    tag_force = "";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    one(2, 6, 3, 16'h55, "R1 sc after reset");
    one(0, 0, 9, 0, "R12 power-up zero");
    one(1, 1, 9, 16'h1234, "R4 store");
    one(3, 7, 9, 0, "R4 code7 load");
    one(0, 2, 4, 0, "R5 tas free");
    one(1, 2, 4, 0, "R5 tas held");
    one(2, 3, 5, 16'hFFFF, "R6 swap");
    one(2, 4, 5, 0, "R7 finc top");
    one(2, 0, 5, 0, "R7 wrapped");
    one(0, 5, 6, 0, "R8 ll");
    one(0, 6, 6, 16'hAA, "R9 sc ok");
    one(0, 0, 6, 0, "R9 sc wrote");
    one(0, 6, 6, 16'hBB, "R10 sc no link");
    one(0, 0, 6, 0, "R10 memory kept");
    one(1, 5, 7, 0, "R8 ll first");
    one(1, 5, 8, 0, "R8 ll replace");
    one(1, 6, 7, 16'h77, "R8 old link gone");
    one(0, 5, 2, 0, "R11 ll a");
    one(3, 5, 2, 0, "R11 ll b");
    one(2, 4, 2, 0, "R11 finc breaks");
    one(0, 6, 2, 16'h9, "R11 sc a fails");
    one(3, 6, 2, 16'h9, "R11 sc b fails");
    one(1, 5, 11, 0, "R11 ll self");
    one(1, 1, 11, 16'h3, "R11 self store");
    one(1, 6, 11, 16'h4, "R11 self sc fails");
    rst = 1'b1;
    req_valid = '0;
    @(negedge clk);
    rst = 1'b0;
    m_last = NREQ - 1;
    for (int r = 0; r < NREQ; r++) m_rv[r] = 0;
    @(negedge clk);
    one(0, 0, 9, 0, "R12 kept over reset");
    req_valid = '0;
    for (int r = 0; r < NREQ; r++) put(r, 0, r, 0);
    for (int k = 0; k < 6; k++) run_cycle();
    for (int k = 0; k < 3000; k++) begin
      for (int r = 0; r < NREQ; r++) begin
        req_valid[r] = ($urandom % 3) != 0;
        req_op[r*3 +: 3] = 3'($urandom);
        req_addr[r*AW +: AW] = AW'($urandom % 4);
        req_wdata[r*DW +: DW] = DW'($urandom);
      end
      run_cycle();
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule